// File: doc/BRIEF.md
# NAND Page Buffer Address Generator

This block sits between a host-side byte port and an internal SRAM that holds flash pages. The SRAM is divided into page-sized slots, each with a pitch of twice the page size, so a slot holds the main area and the spare area of one page. A setup command gives a page number, a starting column, a spare-area flag and a read length. The block picks a slot from the low bits of the page number, turns the column into a byte pointer within that slot, and then serves sequential reads and writes that each move the pointer forward.

The page size comes from a 3-bit code. Code k gives a page of `PAGE_UNIT << k` bytes, and the spare area is that page size shifted right by `SPARE_SHIFT`. The slot mask depends on the page size: 15, 3, 1 and 0 for codes 0 to 3. A double-slot mode widens the mask to mask*2+1. Codes 4 to 7 are not supported. Reads are limited to the loaded length, clamped to page plus spare. A read past that limit returns the filler 0xFF. A write past page plus spare is dropped and flagged.

A small state machine sequences the accesses. READY accepts one request per cycle, with setup taking priority over read and read over write. An accepted read moves READY to FETCH for the single cycle of SRAM latency, and FETCH returns to READY. From READY or FETCH, an unsupported code moves to LOCKED. LOCKED returns to READY once the code is valid again.

Top module: `nand_pgbuf_agen`

## Requirements
- R1: The slot is the page number ANDed with a mask of 15, 3, 1 or 0 for page codes 0, 1, 2 and 3. The slot base is slot × 2 × page bytes, with page bytes = `PAGE_UNIT << code`.
- R2: With `cfg_double_slots` high, the mask becomes mask*2+1 (31, 7, 3, 1).
- R3: Setup loads the pointer with the column, or with column + page bytes when `setup_spare` is high.
- R4: A read accepted with pointer < limit returns the SRAM byte at base+pointer. `rd_valid` is high in the cycle after acceptance, and the pointer advances by 1.
- R5: With `cfg_wide16` high, an in-limit read returns the byte at base+pointer, which is the low byte of the little-endian 16-bit word there, and the pointer advances by 2.
- R6: A read with pointer ≥ limit returns 0xFF with `rd_overrun` high and leaves the pointer unchanged. The limit is min(`setup_len`, page + spare), where spare = page bytes >> `SPARE_SHIFT`. Before any setup, the limit is 0.
- R7: A write with pointer < page + spare stores `wr_data` at base+pointer and advances the pointer by 1. Otherwise nothing is stored, the pointer holds, and `wr_err` is high for the next cycle.
- R8: Page codes 4 to 7 drive `cfg_err` high and `ready` low. Setup, read and write requests are then ignored, and the pointer and buffer are kept.
- R9: At most one request is taken per cycle, with setup before read before write. `ready` is low during the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_code | input | 3 | Page-size code (0..3 valid) |
| cfg_double_slots | input | 1 | Widen slot mask to mask*2+1 |
| cfg_wide16 | input | 1 | 16-bit port read stepping |
| setup_valid | input | 1 | Load page, column, flag and length |
| setup_page | input | PAGE_W | Page number |
| setup_col | input | PTR_W-1 | Starting column |
| setup_spare | input | 1 | Column is relative to the spare area |
| setup_len | input | PTR_W | Read length limit in pointer units |
| rd_req | input | 1 | Read one byte |
| wr_req | input | 1 | Write one byte |
| wr_data | input | 8 | Write byte |
| ready | output | 1 | Requests are accepted this cycle |
| cfg_err | output | 1 | Unsupported page code |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Read byte or 0xFF filler |
| rd_overrun | output | 1 | Read was past the limit |
| wr_err | output | 1 | Previous write was dropped |

## Verification
The bench aims at slot aliasing. Two page numbers that differ only above the mask must reach the same bytes, and double-slot mode must split them. A design with a wrong mask or wrong pitch would read another page's data. It drives the pointer exactly onto the read limit and the write limit, including a read length larger than page plus spare. A design that advanced on overrun, missed the clamp or stored a dropped write would land later bytes at shifted addresses, and the bench detects this by reading back through another page code. It also checks 16-bit stepping, spare-area offsets, and that requests made with an unsupported code leave the pointer and buffer intact.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_FETCH  = 2'd1,
        ST_LOCKED = 2'd2
    } pgbuf_state_e;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam int         MASK_BITS  = 5;
endpackage

// File: rtl/pgbuf_slot_map.sv
module pgbuf_slot_map #(
    parameter int PAGE_UNIT   = 16,
    parameter int SPARE_SHIFT = 2,
    parameter int PAGE_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int PTR_W       = 9
) (
    input  logic [2:0]        page_code,
    input  logic              double_slots,
    input  logic [PAGE_W-1:0] page,
    output logic              code_bad,
    output logic [ADDR_W-1:0] slot_base,
    output logic [PTR_W-1:0]  page_bytes,
    output logic [PTR_W-1:0]  write_lim
);
    import pgbuf_pkg::*;

    logic [MASK_BITS-1:0] base_mask;
    logic [MASK_BITS:0]   eff_mask;
    logic [PAGE_W-1:0]    slot_num;

    always_comb begin
        code_bad = 1'b0;
        unique case (page_code)
            3'd0:    base_mask = 5'd15;
            3'd1:    base_mask = 5'd3;
            3'd2:    base_mask = 5'd1;
            3'd3:    base_mask = 5'd0;
            default: begin
                base_mask = 5'd0;
                code_bad  = 1'b1;
            end
        endcase
    end

    assign eff_mask   = double_slots ? {base_mask, 1'b1} : {1'b0, base_mask};
    assign slot_num   = page & PAGE_W'(eff_mask);
    assign page_bytes = PTR_W'(PAGE_UNIT) << page_code[1:0];
    assign write_lim  = page_bytes + (page_bytes >> SPARE_SHIFT);
    assign slot_base  = ADDR_W'(slot_num) * (ADDR_W'(page_bytes) << 1);
endmodule

// File: rtl/pgbuf_ram.sv
module pgbuf_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          rvalid
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= re;
    end

    // R9: the sequencer never reads and writes the array in one cycle
    a_r9_single_port_use: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({re, we}));
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl #(
    parameter int ADDR_W = 10,
    parameter int PTR_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_bad,
    input  logic              wide16,
    input  logic [ADDR_W-1:0] slot_base,
    input  logic [PTR_W-1:0]  page_bytes,
    input  logic [PTR_W-1:0]  write_lim,
    input  logic              setup_valid,
    input  logic [PTR_W-2:0]  setup_col,
    input  logic              setup_spare,
    input  logic [PTR_W-1:0]  setup_len,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [7:0]        ram_q,
    input  logic              ram_vld,
    output logic              ram_re,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_overrun,
    output logic              wr_err
);
    import pgbuf_pkg::*;

    pgbuf_state_e       state_q, state_d;
    logic [ADDR_W-1:0]  base_q;
    logic [PTR_W-1:0]   ptr_q, rlim_q, wlim_q;
    logic               ovr_q, werr_q;
    logic               setup_go, rd_go, wr_go, rd_in, wr_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next state and request acceptance
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:  if (code_bad) state_d = ST_LOCKED;
                       else if (rd_go) state_d = ST_FETCH;
            ST_FETCH:  state_d = code_bad ? ST_LOCKED : ST_READY;
            ST_LOCKED: if (!code_bad) state_d = ST_READY;
            default:   state_d = ST_READY;
        endcase
    end

    assign ready    = (state_q == ST_READY) && !code_bad;
    assign setup_go = ready && setup_valid;
    assign rd_go    = ready && rd_req && !setup_valid;
    assign wr_go    = ready && wr_req && !setup_valid && !rd_req;
    assign rd_in    = ptr_q < rlim_q;
    assign wr_in    = ptr_q < wlim_q;
    assign ram_re   = rd_go && rd_in;
    assign ram_we   = wr_go && wr_in;
    assign ram_addr = base_q + ADDR_W'(ptr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
            rlim_q <= '0;
            wlim_q <= '0;
            ovr_q  <= 1'b0;
            werr_q <= 1'b0;
        end else begin
            ovr_q  <= rd_go && !rd_in;
            werr_q <= wr_go && !wr_in;
            if (setup_go) begin
                base_q <= slot_base;
                wlim_q <= write_lim;
                rlim_q <= (setup_len > write_lim) ? write_lim : setup_len;
                ptr_q  <= setup_spare ? PTR_W'(setup_col) + page_bytes
                                      : PTR_W'(setup_col);
            end else if (ram_re) begin
                ptr_q <= ptr_q + (wide16 ? PTR_W'(2) : PTR_W'(1));
            end else if (ram_we) begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
        end
    end

    assign rd_valid   = ram_vld || ovr_q;
    assign rd_data    = ovr_q ? FILL_BYTE : ram_q;
    assign rd_overrun = ovr_q;
    assign wr_err     = werr_q;

    // R4: an in-limit read yields data in the next cycle
    a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && rd_in) |=> (rd_valid && !rd_overrun));
    // R5: wide port steps the pointer by two
    a_r5_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && rd_in && wide16) |=> (ptr_q == $past(ptr_q) + PTR_W'(2)));
    // R6: an overrun read holds the pointer and flags filler
    a_r6_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !rd_in) |=> (rd_overrun && $stable(ptr_q)));
    // R7: a dropped write flags and holds the pointer
    a_r7_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !wr_in) |=> (wr_err && $stable(ptr_q)));
    // R8: nothing comes out while locked
    a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> (!rd_valid && !wr_err));
    // R9: one request per cycle
    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({setup_go, rd_go, wr_go}));
endmodule

// File: rtl/nand_pgbuf_agen.sv
module nand_pgbuf_agen #(
    parameter int PAGE_UNIT   = 16,
    parameter int SPARE_SHIFT = 2,
    parameter int PAGE_W      = 16,
    localparam int PTR_W      = $clog2(16 * PAGE_UNIT) + 1,
    localparam int ADDR_W     = $clog2(64 * PAGE_UNIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_page_code,
    input  logic              cfg_double_slots,
    input  logic              cfg_wide16,
    input  logic              setup_valid,
    input  logic [PAGE_W-1:0] setup_page,
    input  logic [PTR_W-2:0]  setup_col,
    input  logic              setup_spare,
    input  logic [PTR_W-1:0]  setup_len,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [7:0]        wr_data,
    output logic              ready,
    output logic              cfg_err,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_overrun,
    output logic              wr_err
);
    localparam int DEPTH = 64 * PAGE_UNIT;

    logic [ADDR_W-1:0] slot_base, ram_addr;
    logic [PTR_W-1:0]  page_bytes, write_lim;
    logic              ram_re, ram_we, ram_vld;
    logic [7:0]        ram_q;

    pgbuf_slot_map #(
        .PAGE_UNIT(PAGE_UNIT), .SPARE_SHIFT(SPARE_SHIFT),
        .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
    ) u_map (
        .page_code(cfg_page_code), .double_slots(cfg_double_slots),
        .page(setup_page), .code_bad(cfg_err), .slot_base(slot_base),
        .page_bytes(page_bytes), .write_lim(write_lim)
    );

    pgbuf_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .code_bad(cfg_err), .wide16(cfg_wide16),
        .slot_base(slot_base), .page_bytes(page_bytes), .write_lim(write_lim),
        .setup_valid(setup_valid), .setup_col(setup_col),
        .setup_spare(setup_spare), .setup_len(setup_len),
        .rd_req(rd_req), .wr_req(wr_req), .ram_q(ram_q), .ram_vld(ram_vld),
        .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_overrun(rd_overrun),
        .wr_err(wr_err)
    );

    pgbuf_ram #(.DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .re(ram_re), .we(ram_we), .addr(ram_addr),
        .wdata(wr_data), .rdata(ram_q), .rvalid(ram_vld)
    );
endmodule

// File: tb/nand_pgbuf_agen_tb.sv
module nand_pgbuf_agen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_page_code = 3'd1;
    logic        cfg_double_slots = 1'b0, cfg_wide16 = 1'b0;
    logic        setup_valid = 1'b0, setup_spare = 1'b0;
    logic [15:0] setup_page = '0;
    logic [7:0]  setup_col = '0;
    logic [8:0]  setup_len = '0;
    logic        rd_req = 1'b0, wr_req = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ready, cfg_err, rd_valid, rd_overrun, wr_err;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nand_pgbuf_agen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_page_code(cfg_page_code),
        .cfg_double_slots(cfg_double_slots), .cfg_wide16(cfg_wide16),
        .setup_valid(setup_valid), .setup_page(setup_page),
        .setup_col(setup_col), .setup_spare(setup_spare),
        .setup_len(setup_len), .rd_req(rd_req), .wr_req(wr_req),
        .wr_data(wr_data), .ready(ready), .cfg_err(cfg_err),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_overrun(rd_overrun),
        .wr_err(wr_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_setup(input int page, input int col, input bit spare, input int len);
        @(negedge clk);
        setup_valid = 1'b1; setup_page = 16'(page); setup_col = 8'(col);
        setup_spare = spare; setup_len = 9'(len);
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic do_write(input int data, input bit exp_err, input string req);
        @(negedge clk);
        wr_req = 1'b1; wr_data = 8'(data);
        @(negedge clk);
        wr_req = 1'b0;
        check(wr_err == exp_err, req, int'(wr_err), int'(exp_err));
    endtask

    task automatic do_read(input int exp, input bit exp_ovr, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid && rd_data == 8'(exp) && rd_overrun == exp_ovr, req,
              int'({rd_valid, rd_overrun, rd_data}), int'({1'b1, exp_ovr, 8'(exp)}));
        check(!ready, "R9 ready low after read", int'(ready), 0);
    endtask

    task automatic t_reset;
        check(ready && !cfg_err && !rd_valid && !wr_err, "R9 reset outputs",
              int'({ready, cfg_err, rd_valid, wr_err}), 8);
        do_read(8'hFF, 1'b1, "R6 read before setup gives filler");
    endtask

    // code 1: 32-byte page, 64-byte pitch, mask 3; page 6 and 10 share slot 2 (base 128)
    task automatic t_slot_alias;
        cfg_page_code = 3'd1;
        do_setup(6, 0, 0, 40);
        for (int i = 0; i < 5; i++) do_write(8'hA0 + i, 1'b0, "R7 write in range");
        do_setup(10, 0, 0, 40);
        for (int i = 0; i < 5; i++) do_read(8'hA0 + i, 1'b0, "R1 R4 aliased page read");
        do_setup(5, 0, 0, 40);
        do_write(8'h50, 1'b0, "R1 write slot 1");
        do_setup(6, 0, 0, 40);
        do_read(8'hA0, 1'b0, "R1 slot 2 not disturbed by slot 1");
    endtask

    // double slots: mask 7; page 6 and 14 share slot 6 (base 384)
    task automatic t_double_slots;
        cfg_double_slots = 1'b1;
        do_setup(6, 0, 0, 40);
        do_write(8'h55, 1'b0, "R2 write slot 6");
        cfg_double_slots = 1'b0;
        do_setup(6, 0, 0, 40);
        do_read(8'hA0, 1'b0, "R2 normal mask still slot 2");
        cfg_double_slots = 1'b1;
        do_setup(14, 0, 0, 40);
        do_read(8'h55, 1'b0, "R2 widened mask slot 6");
        cfg_double_slots = 1'b0;
    endtask

    // spare flag: col 2 + page 32 = pointer 34
    task automatic t_spare;
        do_setup(6, 2, 1, 40);
        do_write(8'h77, 1'b0, "R3 spare write");
        do_setup(6, 34, 0, 40);
        do_read(8'h77, 1'b0, "R3 spare offset equals column plus page");
    endtask

    task automatic t_read_limit;
        do_setup(6, 0, 0, 3);
        do_read(8'hA0, 1'b0, "R6 below limit");
        do_read(8'hA1, 1'b0, "R6 below limit");
        do_read(8'hA2, 1'b0, "R6 last byte");
        do_read(8'hFF, 1'b1, "R6 at limit");
        do_read(8'hFF, 1'b1, "R6 past limit again");
        do_write(8'h99, 1'b0, "R6 pointer held at 3 for write");
        do_setup(6, 3, 0, 40);
        do_read(8'h99, 1'b0, "R6 overrun did not move pointer");
        do_setup(6, 39, 0, 40);
        do_write(8'h39, 1'b0, "R7 write at last spare byte");
        do_setup(6, 39, 0, 200);
        do_read(8'h39, 1'b0, "R6 clamped length read");
        do_read(8'hFF, 1'b1, "R6 length clamped to page plus spare");
    endtask

    // code 2 page 1 col 40 is address 168, where a dropped code-1 write would land
    task automatic t_write_limit;
        cfg_page_code = 3'd2;
        do_setup(1, 40, 0, 80);
        do_write(8'h11, 1'b0, "R7 code 2 write");
        cfg_page_code = 3'd1;
        do_setup(6, 38, 0, 40);
        do_write(8'hC8, 1'b0, "R7 write col 38");
        do_write(8'hC9, 1'b0, "R7 write col 39");
        do_write(8'hCA, 1'b1, "R7 write at limit dropped");
        do_write(8'hCB, 1'b1, "R7 write past limit dropped");
        cfg_page_code = 3'd2;
        do_setup(1, 40, 0, 80);
        do_read(8'h11, 1'b0, "R7 dropped write stored nothing");
        cfg_page_code = 3'd1;
        do_setup(6, 38, 0, 40);
        do_read(8'hC8, 1'b0, "R7 readback col 38");
        do_read(8'hC9, 1'b0, "R7 readback col 39");
    endtask

    // address 131 was rewritten to 99; bytes at 128, 130, 132 are A0, A2, A4
    task automatic t_wide16;
        cfg_wide16 = 1'b1;
        do_setup(6, 0, 0, 5);
        do_read(8'hA0, 1'b0, "R5 word 0 low byte");
        do_read(8'hA2, 1'b0, "R5 step of two");
        do_read(8'hA4, 1'b0, "R5 step of two again");
        do_read(8'hFF, 1'b1, "R5 R6 pointer 6 past length 5");
        cfg_wide16 = 1'b0;
    endtask

    // code 0 page 0x13: slot 3, base 96; code 3: mask 0, base 0
    task automatic t_other_codes;
        cfg_page_code = 3'd0;
        do_setup(16'h13, 0, 0, 20);
        do_write(8'h3C, 1'b0, "R1 code 0 write");
        cfg_page_code = 3'd3;
        do_setup(7, 96, 0, 160);
        do_read(8'h3C, 1'b0, "R1 code 0 base 96 seen via code 3");
        cfg_page_code = 3'd1;
    endtask

    task automatic t_locked;
        do_setup(6, 1, 0, 40);
        @(negedge clk);
        cfg_page_code = 3'd5;
        @(negedge clk);
        check(cfg_err && !ready, "R8 bad code locks", int'({cfg_err, ready}), 2);
        wr_req = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        wr_req = 1'b0;
        check(!wr_err, "R8 write ignored", int'(wr_err), 0);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(!rd_valid, "R8 read ignored", int'(rd_valid), 0);
        setup_valid = 1'b1; setup_page = 16'd5; setup_col = 8'd0;
        @(negedge clk);
        setup_valid = 1'b0;
        cfg_page_code = 3'd1;
        @(negedge clk);
        check(ready && !cfg_err, "R8 unlock", int'({ready, cfg_err}), 2);
        do_read(8'hA1, 1'b0, "R8 pointer and buffer kept");
        @(negedge clk);
        setup_valid = 1'b1; rd_req = 1'b1; setup_page = 16'd6;
        setup_col = 8'd2; setup_spare = 1'b0; setup_len = 9'd40;
        @(negedge clk);
        setup_valid = 1'b0; rd_req = 1'b0;
        check(!rd_valid, "R9 setup wins over read", int'(rd_valid), 0);
        do_read(8'hA2, 1'b0, "R9 read after setup priority");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slot_alias();
        t_double_slots();
        t_spare();
        t_read_limit();
        t_write_limit();
        t_wide16();
        t_other_codes();
        t_locked();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule